// File: doc/BRIEF.md
# Frame-Aligned Output Comparator

This block checks a multi-cycle hardware implementation against a reference that produces one result per frame of N clock cycles. Both streams enter the block every cycle. The implementation result for a frame appears K cycles after the frame starts. The reference result is valid on the first cycle of its frame. The block delays the implementation stream by a few cycles so that its results land on frame boundaries. It delays the sampled reference by whole frames so that both sides describe the same frame. It then compares the two once per frame.

Frame numbering starts at the first clock edge after reset is released, which is edge 0. Edge c is a sampling edge when c mod N = 0. A two-state controller holds back all comparisons while the delay lines still carry data from before reset. It has two states. ST_FILL waits while the delay lines fill. ST_CHECK compares on every sampling edge. The only transition is FILL_DONE, from ST_FILL to ST_CHECK. It is taken on sampling edge F-1, and ST_CHECK is kept until reset.

Each comparison is reported by a one-cycle valid strobe. A differing comparison also raises a one-cycle mismatch strobe and sets a flag that stays set until reset.

Top module: `frame_align_cmp`

## Requirements
- R1: While reset is asserted, `cmp_valid`, `mismatch_pulse` and `mismatch_seen` are all 0.
- R2: `cmp_valid` is 1 only in the cycle that follows a sampling edge c (c mod N = 0, counting edges from 0 after reset release). Once comparisons have begun, it is 1 after every such edge, so consecutive strobes are exactly N cycles apart.
- R3: The implementation stream is delayed by D = N - (K mod N) cycles. When K is a multiple of N, D = N.
- R4: The sampled reference is delayed by F = (K + D) / N frames. This equals ceil(K/N) when K is not a multiple of N, and K/N + 1 when it is. For N=4, K=5 this gives D=3 and F=2. For N=4, K=8 it gives D=4 and F=3.
- R5: No comparison is made on sampling edges 0 to F-1. The first `cmp_valid` appears in the cycle after edge F*N.
- R6: At sampling edge m*N (m >= F), the implementation input of cycle m*N-D is compared with the reference input of cycle (m-F)*N. `mismatch_pulse` is 1 in the following cycle exactly when they differ, and is never 1 without `cmp_valid`.
- R7: Input values on cycles that are not sampled on their path have no effect on any output.
- R8: `mismatch_seen` rises only together with a `mismatch_pulse`, and then stays 1 until reset.
- R9: The controller leaves ST_FILL through FILL_DONE at sampling edge F-1 and never returns to ST_FILL without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| impl_data | input | W | Implementation output stream |
| ref_data | input | W | Reference output stream |
| cmp_valid | output | 1 | One-cycle strobe after each comparison |
| mismatch_pulse | output | 1 | One-cycle strobe when a comparison differs |
| mismatch_seen | output | 1 | Sticky mismatch flag, cleared by reset |

## Verification
The bound checker watches several properties on every cycle: the spacing of the valid strobes, the time of the first comparison after reset, that a mismatch strobe always comes with a valid strobe, the rise and hold of the sticky flag, and that the controller never falls back to filling. The alignment arithmetic can only be shown by the bench scenarios. These cover which implementation cycle meets which reference frame, the K-multiple-of-N case, and the fact that off-sample values are ignored. In each scenario the bench drives streams built so that only a correctly aligned sampler sees equal values.

// File: rtl/fac_pkg.sv
package fac_pkg;

    typedef enum logic [0:0] {
        ST_FILL  = 1'b0,
        ST_CHECK = 1'b1
    } fac_state_e;

    // Cycle delay on the implementation path; a multiple of n gives n.
    function automatic int imp_delay(input int n, input int k);
        return n - (k % n);
    endfunction

    // Whole-frame delay on the reference path, so that K + D = F * N.
    function automatic int ref_frames(input int n, input int k);
        return (k + imp_delay(n, k)) / n;
    endfunction

endpackage

// File: rtl/frame_phase_gen.sv
module frame_phase_gen #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == PW'(N - 1)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == '0);

endmodule

// File: rtl/cycle_delay_line.sv
module cycle_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[i] <= '0;
                    else        stage_q[i] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[i] <= '0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/frame_delay_line.sv
module frame_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] slot_q [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_slot
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        slot_q[i] <= '0;
                    else if (shift_en) slot_q[i] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)        slot_q[i] <= '0;
                    else if (shift_en) slot_q[i] <= slot_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = slot_q[DEPTH-1];

endmodule

// File: rtl/frame_align_cmp.sv
module frame_align_cmp #(
    parameter int W = 16,
    parameter int N = 4,
    parameter int K = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] impl_data,
    input  logic [W-1:0] ref_data,
    output logic         cmp_valid,
    output logic         mismatch_pulse,
    output logic         mismatch_seen
);
    import fac_pkg::*;

    localparam int D   = imp_delay(N, K);
    localparam int F   = ref_frames(N, K);
    localparam int FCW = (F > 1) ? $clog2(F) : 1;

    fac_state_e     state_q, state_d;
    logic [FCW-1:0] fcnt_q;
    logic           tick;
    logic [W-1:0]   imp_tap;
    logic [W-1:0]   ref_tap;
    logic           differ;
    logic           do_cmp;

    frame_phase_gen #(.N(N)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    cycle_delay_line #(.W(W), .DEPTH(D)) u_imp_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (impl_data),
        .dout  (imp_tap)
    );

    frame_delay_line #(.W(W), .DEPTH(F)) u_ref_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (tick),
        .din      (ref_data),
        .dout     (ref_tap)
    );

    assign differ = (imp_tap != ref_tap);
    assign do_cmp = tick && (state_q == ST_CHECK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            fcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL && tick) begin
                fcnt_q <= fcnt_q + 1'b1;
            end
        end
    end

    // Next state: FILL_DONE on sampling edge F-1
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (tick && fcnt_q == FCW'(F - 1)) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = ST_CHECK;
            end
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_valid      <= 1'b0;
            mismatch_pulse <= 1'b0;
            mismatch_seen  <= 1'b0;
        end else begin
            cmp_valid      <= do_cmp;
            mismatch_pulse <= do_cmp && differ;
            if (do_cmp && differ) mismatch_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/frame_align_cmp_chk.sv
module frame_align_cmp_chk #(
    parameter int N = 4,
    parameter int K = 5
) (
    input logic clk,
    input logic rst_n,
    input logic cmp_valid,
    input logic mismatch_pulse,
    input logic mismatch_seen,
    input logic in_check
);
    localparam int F     = fac_pkg::ref_frames(N, K);
    localparam int FIRST = F * N + 1;

    int unsigned cyc_q;
    int unsigned gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= 0;
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else begin
            if (cyc_q < FIRST + 2) cyc_q <= cyc_q + 1;
            if (cmp_valid) begin
                gap_q  <= 0;
                seen_q <= 1'b1;
            end else if (gap_q < N + 2) begin
                gap_q <= gap_q + 1;
            end
        end
    end

    // R2
    valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && seen_q) |-> (gap_q == N - 1));

    // R2
    valid_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !cmp_valid) |-> (gap_q < N - 1));

    // R5
    first_cmp_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !seen_q) |-> (cyc_q == FIRST));

    // R6
    pulse_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_pulse |-> cmp_valid);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_seen |=> mismatch_seen);

    // R8
    sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mismatch_seen) |-> mismatch_pulse);

    // R9
    no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_check |=> in_check);

    // R9
    valid_in_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> in_check);

endmodule

bind frame_align_cmp frame_align_cmp_chk #(.N(N), .K(K)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmp_valid      (cmp_valid),
    .mismatch_pulse (mismatch_pulse),
    .mismatch_seen  (mismatch_seen),
    .in_check       (state_q == fac_pkg::ST_CHECK)
);

// File: tb/sim_frame_align_cmp.sv
`timescale 1ns/1ps
module sim_frame_align_cmp;
    localparam int W    = 16;
    localparam int N    = 4;
    localparam int K0   = 5;
    localparam int K1   = 8;
    localparam int D0   = 3;   // R3: 4 - (5 mod 4)
    localparam int F0   = 2;   // R4: ceil(5/4)
    localparam int D1   = 4;   // R3: K multiple of N
    localparam int F1   = 3;   // R4: 8/4 + 1
    localparam int NCYC = 120;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ref_data = '0;
    logic [W-1:0] impl0 = '0;
    logic [W-1:0] impl1 = '0;
    logic         v0, p0, s0, v1, p1, s1;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [W-1:0] ref_hist [0:255];
    logic [W-1:0] imp0_hist [0:255];
    logic [W-1:0] imp1_hist [0:255];

    always #2.5 clk = ~clk;

    frame_align_cmp #(.W(W), .N(N), .K(K0)) u0 (
        .clk(clk), .rst_n(rst_n), .impl_data(impl0), .ref_data(ref_data),
        .cmp_valid(v0), .mismatch_pulse(p0), .mismatch_seen(s0));

    frame_align_cmp #(.W(W), .N(N), .K(K1)) u1 (
        .clk(clk), .rst_n(rst_n), .impl_data(impl1), .ref_data(ref_data),
        .cmp_valid(v1), .mismatch_pulse(p1), .mismatch_seen(s1));

    task automatic chk(input logic got, input logic exp, input string req,
                       input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] stepv(input int j);
        return W'(j * 37 + 11) ^ 16'h3C00;
    endfunction

    function automatic logic [W-1:0] impl_val(input int mode, input int c, input int k);
        int j;
        if (c >= k && (c - k) % N == 0) begin
            j = (c - k) / N;
            case (mode)
                1: return (j == 5) ? (stepv(j) ^ 16'h0001) : stepv(j);
                3: return (j % 2 == 1) ? (stepv(j) ^ 16'h0100) : stepv(j);
                4: return (j == 0) ? (stepv(j) ^ 16'h8000) : stepv(j);
                default: return stepv(j);
            endcase
        end
        if (mode == 2) return 16'hA5A5 ^ W'(c);
        return (c >= k) ? stepv((c - k) / N) : 16'h0F0F;
    endfunction

    function automatic logic [W-1:0] ref_val(input int mode, input int c);
        if (c % N == 0 || mode != 2) return stepv(c / N);
        return 16'h5A5A ^ W'(c * 3);
    endfunction

    task automatic check_dut(input int c, input int d, input int f,
                             input logic [W-1:0] imp_at, input logic v,
                             input logic p, input logic s, inout logic exp_s,
                             input string tag);
        logic exp_v, exp_p;
        exp_v = (c % N == 0) && (c / N >= f);
        exp_p = exp_v && (imp_at != ref_hist[c - f * N]);
        if (exp_p) exp_s = 1'b1;
        chk(v, exp_v, (c / N < f) ? "R5" : "R2", {tag, " valid"});
        chk(p, exp_p, "R6", {tag, " pulse (R3 R4 R7 alignment)"});
        chk(s, exp_s, "R8", {tag, " sticky"});
    endtask

    task automatic run_case(input int mode, input string name);
        logic es0, es1;
        rst_n    = 1'b0;
        ref_data = 16'hFFFF;
        impl0    = 16'hFFFF;
        impl1    = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk(v0 | v1, 1'b0, "R1", {name, " valid in reset"});
        chk(p0 | p1, 1'b0, "R1", {name, " pulse in reset"});
        chk(s0 | s1, 1'b0, "R1", {name, " sticky in reset"});
        rst_n = 1'b1;
        es0 = 1'b0;
        es1 = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            ref_data     = ref_val(mode, c);
            impl0        = impl_val(mode, c, K0);
            impl1        = impl_val(mode, c, K1);
            ref_hist[c]  = ref_data;
            imp0_hist[c] = impl0;
            imp1_hist[c] = impl1;
            @(negedge clk);
            check_dut(c, D0, F0, (c >= D0) ? imp0_hist[c - D0] : 16'h0000,
                      v0, p0, s0, es0, {name, " K5"});
            check_dut(c, D1, F1, (c >= D1) ? imp1_hist[c - D1] : 16'h0000,
                      v1, p1, s1, es1, {name, " K8"});
        end
    endtask

    task automatic scen_clean();        run_case(0, "clean hold");      endtask
    task automatic scen_single_err();   run_case(1, "single error");    endtask
    task automatic scen_off_sample();   run_case(2, "off-sample noise"); endtask
    task automatic scen_many_err();     run_case(3, "odd-step errors"); endtask
    task automatic scen_first_err();    run_case(4, "first-step error"); endtask

    task automatic scen_sticky_cleared();
        // R8 / R1: sticky flag from the previous run is cleared by reset
        run_case(1, "pre-reset error");
        chk(s0 & s1, 1'b1, "R8", "sticky set before reset");
        rst_n = 1'b0;
        @(negedge clk);
        chk(s0 | s1, 1'b0, "R1", "sticky cleared by reset");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        scen_clean();
        scen_single_err();
        scen_off_sample();
        scen_many_err();
        scen_first_err();
        scen_sticky_cleared();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule